// File: doc/BRIEF.md
# Beacon Target Time Timer Bank

This block keeps a 64-bit microsecond timestamp and four periodic event timers that hang off it. The timers mark the beacon transmit target, an early alert for beacon DMA, an early alert for software beacon preparation, and the end of the announcement (NDP) window. A microsecond strobe from outside advances the timestamp. A narrow register write port loads the next target of each timer, the common beacon interval and the timer enables. A combinational read port returns the targets, the period, the enables and the live timestamp.

Targets arrive in two scales. The beacon and window-end targets are given in whole time units of 1024 us. The two alert targets are given in eighths of a time unit, 128 us each. Every target is converted to microseconds when it is written. One interval field sets the period of all four timers. When the timestamp reaches an enabled target, the timer emits a single-cycle pulse and moves its target forward by one period.

A flag in the interval write clears the timestamp. A zero enable write selects a default set of timers. The window-end target is never allowed to fall less than one time unit after the beacon target.

Top module: `beacon_timer_bank`

## Requirements
- R1: After reset the timestamp, all four targets, the period and the enable bits read as zero, and no event output is high.
- R2: The timestamp (read address 7) increases by exactly one on each clock edge where `tick_us` is high. It holds its value when `tick_us` is low.
- R3: A write to address 0 (beacon target) stores the write data shifted left by 10 (time units to microseconds). The stored value reads back at the same address.
- R4: A write to address 1 (DMA alert) or address 2 (software alert) stores the write data shifted left by 7 (eighths of a unit to microseconds). The stored value reads back at the same address.
- R5: A write to address 4 sets the period of all four timers to data bits [15:0] shifted left by 10. Data bits [31:17] have no effect. The period reads back at address 4.
- R6: A write to address 4 with data bit 16 set makes the timestamp read zero on the next cycle, even when `tick_us` is high on that edge.
- R7: A write to address 5 ORs data bits [3:0] into the enable bits: bit 0 beacon, bit 1 DMA alert, bit 2 software alert, bit 3 window end. A write of zero in those bits ORs in 4'b0111 instead. The enables read back at address 5 and are never cleared except by reset.
- R8: Once the timestamp is greater than or equal to an enabled timer's target, that timer's bit of `evt_o` is high for one cycle on the following cycle, and its target advances by the period. With `tick_us` high every cycle, the timestamp reads target+1 while the pulse is high.
- R9: A timer whose enable bit is clear never pulses, and its target does not change.
- R10: A write to address 3 stores the larger of (data shifted left by 10) and (current beacon target + 1024).
- R11: A target write to an enabled timer replaces its pending target. The next pulse follows the new value, and a compare hit in the cycle of the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | Microsecond strobe that advances the timestamp |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 64 | Read data (combinational) |
| evt_o | output | 4 | Event pulses: bit 0 beacon, 1 DMA alert, 2 software alert, 3 window end |

## Verification
A wrong target or period does not stay hidden. The next pulse of that timer arrives at a timestamp other than target+1, and every later pulse drifts by the same error, so one interval is enough to expose it. A stuck enable or a lost advance shows as a missing pulse, or as a pulse on every cycle, within one period. A timestamp that miscounts or misses its clear shows on the read port on the very next cycle. The bench records the timestamp at each pulse over several periods for each timer and compares it with base plus multiples of the interval.

// File: rtl/bt_timer_pkg.sv
package bt_timer_pkg;
  localparam int BT_TSF_W     = 64;
  localparam int BT_DATA_W    = 32;
  localparam int BT_ADDR_W    = 3;
  localparam int BT_NUM_TMR   = 4;
  localparam int BT_TU_SHIFT  = 10;
  localparam int BT_SUB_SHIFT = 7;
  localparam int BT_IVL_W     = 16;
  localparam int BT_CLR_BIT   = 16;

  typedef enum logic [1:0] {
    TMR_BEACON = 2'd0,
    TMR_DMA    = 2'd1,
    TMR_SWA    = 2'd2,
    TMR_WEND   = 2'd3
  } tmr_id_e;

  localparam logic [BT_ADDR_W-1:0] A_PERIOD = 3'd4;
  localparam logic [BT_ADDR_W-1:0] A_MODE   = 3'd5;
  localparam logic [BT_ADDR_W-1:0] A_TSF    = 3'd7;

  localparam logic [BT_NUM_TMR-1:0] BT_DEFAULT_EN = 4'b0111;

  function automatic logic [BT_TSF_W-1:0] tu_to_us(input logic [BT_DATA_W-1:0] v);
    return {{(BT_TSF_W-BT_DATA_W){1'b0}}, v} << BT_TU_SHIFT;
  endfunction

  function automatic logic [BT_TSF_W-1:0] sub_to_us(input logic [BT_DATA_W-1:0] v);
    return {{(BT_TSF_W-BT_DATA_W){1'b0}}, v} << BT_SUB_SHIFT;
  endfunction

  function automatic logic [BT_TSF_W-1:0] ivl_to_us(input logic [BT_IVL_W-1:0] v);
    return {{(BT_TSF_W-BT_IVL_W){1'b0}}, v} << BT_TU_SHIFT;
  endfunction

  function automatic logic [BT_NUM_TMR-1:0] mode_merge(input logic [BT_NUM_TMR-1:0] cur,
                                                      input logic [BT_NUM_TMR-1:0] req);
    return (req == '0) ? (cur | BT_DEFAULT_EN) : (cur | req);
  endfunction

  function automatic logic [BT_TSF_W-1:0] wend_floor(input logic [BT_TSF_W-1:0] req_us,
                                                    input logic [BT_TSF_W-1:0] beacon_us);
    logic [BT_TSF_W-1:0] lo;
    lo = beacon_us + (BT_TSF_W'(1) << BT_TU_SHIFT);
    return (req_us < lo) ? lo : req_us;
  endfunction
endpackage

// File: rtl/bt_tsf_counter.sv
module bt_tsf_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] tsf_o
);
  logic [W-1:0] tsf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tsf_q <= '0;
    else if (clr)    tsf_q <= '0;
    else if (tick)   tsf_q <= tsf_q + W'(1);
  end

  assign tsf_o = tsf_q;

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (tsf_o == $past(tsf_o) + W'(1)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(tsf_o));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tsf_o == '0));
endmodule

// File: rtl/bt_event_timer.sv
module bt_event_timer #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] tsf,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] tgt_o,
  output logic         hit_o,
  output logic         evt_o
);
  logic [W-1:0] tgt_q;
  logic         evt_q;
  logic         hit;

  assign hit = en && (tsf >= tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      if (ld)       tgt_q <= ld_val;
      else if (hit) tgt_q <= tgt_q + period;
      evt_q <= hit && !ld;
    end
  end

  assign tgt_o = tgt_q;
  assign hit_o = hit;
  assign evt_o = evt_q;

  assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ld) |=> (evt_o && tgt_o == $past(tgt_o) + $past(period)));
  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> (!evt_o && $stable(tgt_o)));
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (!evt_o && tgt_o == $past(ld_val)));
endmodule

// File: rtl/bt_cfg_regs.sv
module bt_cfg_regs
  import bt_timer_pkg::*;
#(
  parameter int TSF_W  = BT_TSF_W,
  parameter int DATA_W = BT_DATA_W,
  parameter int ADDR_W = BT_ADDR_W,
  parameter int NUM    = BT_NUM_TMR
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [TSF_W-1:0]          beacon_tgt,
  output logic [NUM-1:0]            ld_o,
  output logic [NUM-1:0][TSF_W-1:0] ld_val_o,
  output logic [TSF_W-1:0]          period_o,
  output logic [NUM-1:0]            mode_o,
  output logic                      clr_o
);
  logic [TSF_W-1:0] period_q;
  logic [NUM-1:0]   mode_q;
  logic             wr_period;
  logic             wr_mode;

  assign wr_period = we && (addr == A_PERIOD);
  assign wr_mode   = we && (addr == A_MODE);

  for (genvar i = 0; i < NUM; i++) begin : g_ld
    assign ld_o[i] = we && (addr == ADDR_W'(i));
    if (i == int'(TMR_DMA) || i == int'(TMR_SWA)) begin : g_sub
      assign ld_val_o[i] = sub_to_us(wdata);
    end else if (i == int'(TMR_WEND)) begin : g_wend
      assign ld_val_o[i] = wend_floor(tu_to_us(wdata), beacon_tgt);
    end else begin : g_tu
      assign ld_val_o[i] = tu_to_us(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      mode_q   <= '0;
    end else begin
      if (wr_period) period_q <= ivl_to_us(wdata[BT_IVL_W-1:0]);
      if (wr_mode)   mode_q   <= mode_merge(mode_q, wdata[NUM-1:0]);
    end
  end

  assign period_o = period_q;
  assign mode_o   = mode_q;
  assign clr_o    = wr_period && wdata[BT_CLR_BIT];

  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mode_o & $past(mode_o)) == $past(mode_o)));
  assert_mode_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_o != '0));
endmodule

// File: rtl/beacon_timer_bank.sv
module beacon_timer_bank
  import bt_timer_pkg::*;
#(
  parameter int TSF_W  = BT_TSF_W,
  parameter int DATA_W = BT_DATA_W,
  parameter int ADDR_W = BT_ADDR_W,
  parameter int NUM    = BT_NUM_TMR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TSF_W-1:0]  rd_data,
  output logic [NUM-1:0]    evt_o
);
  localparam logic [TSF_W-1:0] ONE_TU = TSF_W'(1) << BT_TU_SHIFT;

  logic [TSF_W-1:0]          tsf;
  logic                      tsf_clr;
  logic [NUM-1:0]            ld;
  logic [NUM-1:0][TSF_W-1:0] ld_val;
  logic [NUM-1:0][TSF_W-1:0] tgt;
  logic [NUM-1:0]            hit;
  logic [TSF_W-1:0]          period;
  logic [NUM-1:0]            mode;

  bt_tsf_counter #(.W(TSF_W)) u_tsf (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_us),
    .clr   (tsf_clr),
    .tsf_o (tsf)
  );

  bt_cfg_regs #(.TSF_W(TSF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM(NUM)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .beacon_tgt (tgt[TMR_BEACON]),
    .ld_o       (ld),
    .ld_val_o   (ld_val),
    .period_o   (period),
    .mode_o     (mode),
    .clr_o      (tsf_clr)
  );

  for (genvar i = 0; i < NUM; i++) begin : g_tmr
    bt_event_timer #(.W(TSF_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (mode[i]),
      .tsf    (tsf),
      .ld     (ld[i]),
      .ld_val (ld_val[i]),
      .period (period),
      .tgt_o  (tgt[i]),
      .hit_o  (hit[i]),
      .evt_o  (evt_o[i])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NUM))    rd_data = tgt[rd_addr[1:0]];
    else if (rd_addr == A_PERIOD)  rd_data = period;
    else if (rd_addr == A_MODE)    rd_data = TSF_W'(mode);
    else if (rd_addr == A_TSF)     rd_data = tsf;
  end

  assert_wend_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld[TMR_WEND] |=> (tgt[TMR_WEND] >= $past(tgt[TMR_BEACON]) + ONE_TU));
  assert_event_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_o & ~$past(mode)) == '0));
  assert_event_from_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_o & ~$past(hit)) == '0));
endmodule

// File: tb/tb_beacon_timer_bank.sv
module tb_beacon_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rd_addr = 3'd7;
  logic [63:0] rd_data;
  logic [3:0]  evt_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit          mon_on = 1'b0;
  logic [63:0] base [4];
  logic [63:0] per;
  int          got [4];

  always #2 clk = ~clk;

  beacon_timer_bank dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt_o(evt_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_us = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    rd_addr = a; #1; v = rd_data; rd_addr = 3'd7;
  endtask

  function automatic int exp_count(input logic [63:0] b, input logic [63:0] p, input int n);
    int c = 0;
    for (int k = 0; k < 64; k++) if (b + 64'(k) * p + 1 <= 64'(n)) c++;
    return c;
  endfunction

  // Event monitor: timestamp at a pulse must be base + k*period + 1 (R8)
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (evt_o[i]) begin
          chk($sformatf("R8 timer%0d pulse %0d time", i, got[i]), rd_data,
              base[i] + 64'(got[i]) * per + 1);
          got[i]++;
        end
      end
    end
  end

  task automatic run_and_count(input int n, input logic [3:0] en, input string req);
    for (int i = 0; i < 4; i++) got[i] = 0;
    mon_on = 1'b1;
    tick_us = 1'b1;
    repeat (n) @(negedge clk);
    tick_us = 1'b0;
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    for (int i = 0; i < 4; i++)
      chk($sformatf("%s timer%0d count", req, i), 64'(got[i]),
          en[i] ? 64'(exp_count(base[i], per, n)) : 64'd0);
  endtask

  initial begin
    logic [63:0] v;
    logic [63:0] t0;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 addr %0d after reset", a), v, 64'd0);
    end
    chk("R1 events after reset", 64'(evt_o), 64'd0);

    // R3/R4/R5 unit conversion and readback
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd6);
    wr(3'd2, 32'd4);
    wr(3'd3, 32'd2);
    wr(3'd4, 32'd2);
    rd(3'd0, v); chk("R3 beacon target", v, 64'd1024);
    rd(3'd1, v); chk("R4 dma target", v, 64'd768);
    rd(3'd2, v); chk("R4 sw target", v, 64'd512);
    rd(3'd3, v); chk("R10 wend target above floor", v, 64'd2048);
    rd(3'd4, v); chk("R5 period", v, 64'd2048);
    rd(3'd7, v); chk("R6 no clear without flag", v, 64'd0);

    // R7 default enable set, then run (R8, R9)
    wr(3'd5, 32'd0);
    rd(3'd5, v); chk("R7 default enables", v, 64'd7);
    base[0] = 1024; base[1] = 768; base[2] = 512; base[3] = 2048; per = 2048;
    run_and_count(7300, 4'b0111, "R8 default set");
    rd(3'd3, v); chk("R9 disabled target unchanged", v, 64'd2048);
    rd(3'd0, v); chk("R8 beacon target advanced", v, 64'd1024 + 4 * 64'd2048);

    // R2 tick gating
    rd(3'd7, t0);
    repeat (20) @(negedge clk);
    rd(3'd7, v); chk("R2 hold without tick", v, t0);
    tick_us = 1'b1; repeat (37) @(negedge clk); tick_us = 1'b0;
    rd(3'd7, v); chk("R2 count ticks", v, t0 + 37);

    // R6 clear with tick high, R5 upper bits ignored
    tick_us = 1'b1;
    wr(3'd4, 32'h0001_0003);
    tick_us = 1'b0;
    rd(3'd7, v); chk("R6 timestamp cleared", v, 64'd0);
    rd(3'd4, v); chk("R5 period after clear write", v, 64'd3072);
    wr(3'd4, 32'hFFFE_FFFF);
    rd(3'd4, v); chk("R5 max interval, high bits ignored", v, 64'hFFFF << 10);
    rd(3'd7, v); chk("R5 bit16 clear means no reset", v, 64'd0);

    // R7 OR semantics
    do_reset();
    wr(3'd5, 32'd4);
    rd(3'd5, v); chk("R7 set bit2", v, 64'd4);
    wr(3'd5, 32'd1);
    rd(3'd5, v); chk("R7 OR bit0", v, 64'd5);
    wr(3'd5, 32'd0);
    rd(3'd5, v); chk("R7 zero ORs default", v, 64'd7);

    // R10 clamp and window-end only run
    do_reset();
    wr(3'd0, 32'd3);
    wr(3'd3, 32'd1);
    rd(3'd3, v); chk("R10 wend clamped", v, 64'd4096);
    wr(3'd3, 32'd5);
    rd(3'd3, v); chk("R10 wend not clamped", v, 64'd5120);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    wr(3'd5, 32'd8);
    rd(3'd5, v); chk("R7 only bit3", v, 64'd8);
    base[0] = 3072; base[1] = 0; base[2] = 0; base[3] = 4096; per = 1024;
    run_and_count(6000, 4'b1000, "R9 wend only");
    rd(3'd0, v); chk("R9 beacon target untouched", v, 64'd3072);

    // R11 rewrite while enabled
    do_reset();
    wr(3'd0, 32'd1);
    wr(3'd4, 32'd4);
    wr(3'd5, 32'd1);
    base[0] = 2048; base[1] = 0; base[2] = 0; base[3] = 0; per = 4096;
    for (int i = 0; i < 4; i++) got[i] = 0;
    mon_on = 1'b1;
    tick_us = 1'b1;
    repeat (500) @(negedge clk);
    wr(3'd0, 32'd2);
    repeat (2499) @(negedge clk);
    tick_us = 1'b0;
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    chk("R11 pulses after rewrite", 64'(got[0]), 64'(exp_count(64'd2048, 64'd4096, 3000)));
    rd(3'd0, v); chk("R11 target advanced from new value", v, 64'd2048 + 64'd4096);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule